// File: doc/BRIEF.md
# MII Transmit Framer with Auto-Pad and FCS

This block turns a stream of frame bytes, read from a transmit FIFO, into the nibble-wide transmit side of a media-independent interface. The caller supplies only the data portion of the frame: destination address, source address, length/type and payload. The block adds the preamble and the start delimiter in front of the data. When asked, it appends zero padding up to the minimum data length. When asked, it also appends a CRC-32 frame check sequence.

A frame starts only when two things are true: the FIFO fill level has reached a threshold set by the caller, and the channel is reported free. The pad and FCS choices are taken per frame, at the moment the frame starts. After the last nibble, the block holds off for a fixed number of idle cycles before it will start another frame. It pulses `done` once when the frame ends and holds `busy` until that gap is over.

Top module: `mii_tx_framer`

## Requirements
- R1: While reset is held and in the first cycle after it, `tx_en`, `busy`, `done` and `fifo_rd` are all 0.
- R2: A frame starts only from idle and only in a cycle where `fifo_level >= threshold` and `chan_free` is 1. `tx_en` goes high in the cycle after that condition is sampled. If either half of the condition is false, no frame starts.
- R3: Every frame begins with fifteen nibbles of 0x5 and then one nibble of 0xD on `txd`. `tx_en` stays high without a break from the first preamble nibble through the last nibble of the frame.
- R4: Each data byte is taken from the FIFO with exactly one `fifo_rd` pulse, and `fifo_rd` is only asserted while `tx_en` is high. Each byte is sent low nibble first, then high nibble. The byte presented with `fifo_last` = 1 is the last data byte.
- R5: If `pad_en` was 1 at the start of the frame and the data portion is shorter than 60 bytes, bytes of 0x00 are sent after the data until 60 bytes have gone out.
- R6: If `pad_en` was 0, or the data portion is already 60 bytes or longer, no padding is sent.
- R7: If `fcs_en` was 1 at the start of the frame, eight FCS nibbles follow the data and padding. The CRC-32 is computed LSB first with the reflected polynomial 0xEDB88320 and a preset of 0xFFFFFFFF, over the data and the pad bytes. The remainder is complemented and sent low byte first, each byte low nibble first. For the nine ASCII bytes "123456789", the FCS nibbles are 6,2,9,3,4,F,B,C.
- R8: If `fcs_en` was 0 at the start of the frame, the frame ends right after the data or padding, with no FCS.
- R9: `done` is a single-cycle pulse in the first cycle in which `tx_en` is low after a frame. `busy` is high in that cycle and stays high until the inter-frame gap has elapsed.
- R10: Between the end of one frame and the start of the next, `tx_en` stays low for at least IFG_CYC cycles (default 24), even when the next frame's start condition already holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit nibble clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_level | input | LW | Number of bytes currently held in the FIFO |
| threshold | input | LW | Fill level needed before a frame may start |
| fifo_data | input | 8 | Byte at the FIFO head (show-ahead) |
| fifo_last | input | 1 | Marks the head byte as the last data byte of the frame |
| fifo_rd | output | 1 | Pops the head byte at the clock edge |
| chan_free | input | 1 | Channel access is permitted |
| pad_en | input | 1 | Pad short frames; sampled when a frame starts |
| fcs_en | input | 1 | Append the FCS; sampled when a frame starts |
| tx_en | output | 1 | MII transmit enable |
| txd | output | 4 | MII transmit nibble |
| busy | output | 1 | A frame or the gap after it is in progress |
| done | output | 1 | One-cycle pulse when a frame ends |

## Verification
The hardest condition to reach from the ports is a start request that arrives while the block is still inside its post-frame gap. Reaching it needs a second frame whose threshold and channel condition are already met in the very cycle `done` rises. The bench refills its FIFO model at that exact edge and leaves `chan_free` high. It then counts the idle cycles before `tx_en` rises again. The start gate is also probed on its own: each half of the condition is held false for many cycles while the other half is true.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_SFD, ST_DATA, ST_PAD, ST_FCS, ST_GAP
  } txst_e;

  localparam int unsigned PRE_NIBS = 15;
  localparam int unsigned FCS_NIBS = 8;
  localparam logic [3:0]  NIB_PRE  = 4'h5;
  localparam logic [3:0]  NIB_SFD  = 4'hD;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // Advance a reflected CRC-32 register by one nibble, LSB first.
  function automatic logic [31:0] crc32_nib(input logic [31:0] crc_in,
                                            input logic [3:0]  nib);
    logic [31:0] c;
    c = crc_in;
    for (int i = 0; i < 4; i++) begin
      if (c[0] ^ nib[i]) c = (c >> 1) ^ CRC_POLY_REFL;
      else               c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/mii_tx_crc.sv
module mii_tx_crc
  import mii_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [3:0]  nib,
  output logic [31:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '1;
    else if (clr) crc <= '1;
    else if (en)  crc <= crc32_nib(crc, nib);
  end
endmodule

// File: rtl/mii_tx_ctrl.sv
module mii_tx_ctrl
  import mii_tx_pkg::*;
#(
  parameter int unsigned LW       = 8,
  parameter int unsigned MIN_DATA = 60,
  parameter int unsigned IFG_CYC  = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] fifo_level,
  input  logic [LW-1:0] threshold,
  input  logic [7:0]    fifo_data,
  input  logic          fifo_last,
  input  logic          chan_free,
  input  logic          pad_en,
  input  logic          fcs_en,
  output txst_e         state,
  output logic [2:0]    fcs_idx,
  output logic [7:0]    cur_byte,
  output logic          nib_hi,
  output logic          fifo_rd,
  output logic          crc_clr,
  output logic          crc_en,
  output logic          done
);
  localparam int unsigned CMAX = (IFG_CYC > PRE_NIBS) ? IFG_CYC : PRE_NIBS;
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam int unsigned BW   = $clog2(MIN_DATA + 1);
  localparam logic [BW-1:0] BC_MAX = '1;

  logic [CW-1:0] cnt;
  logic [BW-1:0] byte_cnt, bc_inc;
  logic          cur_last, pad_q, fcs_q;
  logic          start_ok, pad_more;
  txst_e         after_body;

  // Named events used by the datapath and the checker
  assign start_ok = (fifo_level >= threshold) && chan_free;
  assign bc_inc   = (byte_cnt == BC_MAX) ? byte_cnt : byte_cnt + BW'(1);
  assign pad_more = pad_q && (bc_inc < BW'(MIN_DATA));
  assign after_body = fcs_q ? ST_FCS : ST_GAP;
  assign fifo_rd  = (state == ST_SFD) || (state == ST_DATA && nib_hi && !cur_last);
  assign crc_clr  = (state == ST_IDLE);
  assign crc_en   = (state == ST_DATA) || (state == ST_PAD);
  assign fcs_idx  = cnt[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      byte_cnt <= '0;
      cur_byte <= '0;
      cur_last <= 1'b0;
      nib_hi   <= 1'b0;
      pad_q    <= 1'b0;
      fcs_q    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_ok) begin
          state    <= ST_PRE;
          cnt      <= '0;
          byte_cnt <= '0;
          pad_q    <= pad_en;
          fcs_q    <= fcs_en;
        end
        ST_PRE: begin
          if (cnt == CW'(PRE_NIBS - 1)) state <= ST_SFD;
          else                          cnt   <= cnt + CW'(1);
        end
        ST_SFD: begin
          state    <= ST_DATA;
          cur_byte <= fifo_data;
          cur_last <= fifo_last;
          nib_hi   <= 1'b0;
        end
        ST_DATA: begin
          nib_hi <= ~nib_hi;
          if (nib_hi) begin
            byte_cnt <= bc_inc;
            if (!cur_last) begin
              cur_byte <= fifo_data;
              cur_last <= fifo_last;
            end else begin
              cnt <= '0;
              if (pad_more) state <= ST_PAD;
              else begin
                state <= after_body;
                done  <= !fcs_q;
              end
            end
          end
        end
        ST_PAD: begin
          nib_hi <= ~nib_hi;
          if (nib_hi) begin
            byte_cnt <= bc_inc;
            if (!pad_more) begin
              state <= after_body;
              done  <= !fcs_q;
            end
          end
        end
        ST_FCS: begin
          if (cnt == CW'(FCS_NIBS - 1)) begin
            state <= ST_GAP;
            cnt   <= '0;
            done  <= 1'b1;
          end else cnt <= cnt + CW'(1);
        end
        ST_GAP: begin
          if (cnt >= CW'(IFG_CYC - 1)) state <= ST_IDLE;
          else                         cnt   <= cnt + CW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mii_tx_framer.sv
module mii_tx_framer
  import mii_tx_pkg::*;
#(
  parameter int unsigned LW       = 8,
  parameter int unsigned MIN_DATA = 60,
  parameter int unsigned IFG_CYC  = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] fifo_level,
  input  logic [LW-1:0] threshold,
  input  logic [7:0]    fifo_data,
  input  logic          fifo_last,
  output logic          fifo_rd,
  input  logic          chan_free,
  input  logic          pad_en,
  input  logic          fcs_en,
  output logic          tx_en,
  output logic [3:0]    txd,
  output logic          busy,
  output logic          done
);
  txst_e       state;
  logic [2:0]  fcs_idx;
  logic [7:0]  cur_byte;
  logic        nib_hi, crc_clr, crc_en;
  logic [3:0]  body_nib;
  logic [31:0] crc_q, fcs_word;

  mii_tx_ctrl #(.LW(LW), .MIN_DATA(MIN_DATA), .IFG_CYC(IFG_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .threshold(threshold),
    .fifo_data(fifo_data), .fifo_last(fifo_last), .chan_free(chan_free),
    .pad_en(pad_en), .fcs_en(fcs_en), .state(state), .fcs_idx(fcs_idx),
    .cur_byte(cur_byte), .nib_hi(nib_hi), .fifo_rd(fifo_rd),
    .crc_clr(crc_clr), .crc_en(crc_en), .done(done)
  );

  assign body_nib = (state == ST_PAD) ? 4'h0 :
                    (nib_hi ? cur_byte[7:4] : cur_byte[3:0]);

  mii_tx_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
    .nib(body_nib), .crc(crc_q)
  );

  assign fcs_word = ~crc_q;

  always_comb begin
    unique case (state)
      ST_PRE:           txd = NIB_PRE;
      ST_SFD:           txd = NIB_SFD;
      ST_DATA, ST_PAD:  txd = body_nib;
      ST_FCS:           txd = fcs_word[{fcs_idx, 2'b00} +: 4];
      default:          txd = 4'h0;
    endcase
  end

  assign tx_en = (state != ST_IDLE) && (state != ST_GAP);
  assign busy  = (state != ST_IDLE);
endmodule

// File: rtl/mii_tx_framer_chk.sv
module mii_tx_framer_chk #(
  parameter int unsigned LW      = 8,
  parameter int unsigned IFG_CYC = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_en,
  input logic [3:0]    txd,
  input logic          fifo_rd,
  input logic          done,
  input logic          busy,
  input logic [LW-1:0] fifo_level,
  input logic [LW-1:0] threshold,
  input logic          chan_free
);
  localparam int unsigned GW = $clog2(IFG_CYC + 2);
  logic [GW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          low_cnt <= GW'(IFG_CYC);
    else if (tx_en)                      low_cnt <= '0;
    else if (low_cnt < GW'(IFG_CYC + 1)) low_cnt <= low_cnt + GW'(1);
  end

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> $past((fifo_level >= threshold) && chan_free)); // R2
  AST_PREAMBLE_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> (txd == 4'h5)); // R3
  AST_READ_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> tx_en); // R4
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($fell(tx_en) && busy)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> (low_cnt >= GW'(IFG_CYC))); // R10
endmodule

bind mii_tx_framer mii_tx_framer_chk #(.LW(LW), .IFG_CYC(IFG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .txd(txd), .fifo_rd(fifo_rd),
  .done(done), .busy(busy), .fifo_level(fifo_level), .threshold(threshold),
  .chan_free(chan_free)
);

// File: tb/mii_tx_framer_tb.sv
module mii_tx_framer_tb;
  localparam int LW = 8;
  localparam int IFG = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LW-1:0] fifo_level, threshold = '0;
  logic [7:0] fifo_data;
  logic fifo_last, fifo_rd, chan_free = 1'b0, pad_en = 1'b0, fcs_en = 1'b0;
  logic tx_en, busy, done;
  logic [3:0] txd;

  always #10 clk = ~clk;

  logic [7:0] mem [0:127];
  int flen = 0;
  int ptr = 0;
  logic ptr_clr = 1'b0;
  always @(posedge clk) begin
    if (ptr_clr)      ptr <= 0;
    else if (fifo_rd) ptr <= ptr + 1;
  end
  assign fifo_level = (ptr < flen) ? LW'(flen - ptr) : '0;
  assign fifo_data  = mem[ptr[6:0]];
  assign fifo_last  = (ptr == flen - 1);

  mii_tx_framer #(.LW(LW), .MIN_DATA(60), .IFG_CYC(IFG)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .threshold(threshold),
    .fifo_data(fifo_data), .fifo_last(fifo_last), .fifo_rd(fifo_rd),
    .chan_free(chan_free), .pad_en(pad_en), .fcs_en(fcs_en),
    .tx_en(tx_en), .txd(txd), .busy(busy), .done(done)
  );

  int nchk = 0, nfail = 0;
  logic [3:0] cap [0:255];
  int ncap = 0;
  int nrd = 0;
  always @(negedge clk) begin
    if (tx_en && ncap < 256) begin cap[ncap] = txd; ncap++; end
    if (fifo_rd) nrd++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n, input int plen);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n + plen; i++) begin
      c ^= {24'h0, (i < n) ? mem[i] : 8'h00};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic load(input int len, input int seed);
    for (int i = 0; i < len; i++) mem[i] = 8'((i * 37 + seed * 11 + 3) ^ (i >> 2));
  endtask

  task automatic arm(input int len, input bit pe, input bit fe, input int thr);
    flen = len; pad_en = pe; fcs_en = fe; threshold = LW'(thr);
    ncap = 0; nrd = 0; ptr_clr = 1'b1;
    @(negedge clk); ptr_clr = 1'b0;
  endtask

  task automatic finish_frame(input int len, input bit pe, input bit fe, input string req);
    logic [3:0] exp [0:255];
    int ne = 0, plen, bad = 0, t = 0;
    logic [31:0] f;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    chk(done === 1'b1, "R9 done pulse", done, 1);
    chk(busy === 1'b1, "R9 busy in gap", busy, 1);
    plen = (pe && len < 60) ? 60 - len : 0;
    for (int i = 0; i < 15; i++) exp[ne++] = 4'h5;
    exp[ne++] = 4'hD;
    for (int i = 0; i < len + plen; i++) begin
      logic [7:0] b = (i < len) ? mem[i] : 8'h00;
      exp[ne++] = b[3:0]; exp[ne++] = b[7:4];
    end
    if (fe) begin
      f = ref_crc(len, plen);
      for (int i = 0; i < 8; i++) exp[ne++] = f[i*4 +: 4];
    end
    chk(ncap == ne, {req, " nibble count"}, ncap, ne);
    chk(nrd == len, "R4 one pop per byte", nrd, len);
    for (int i = 0; i < ne && i < ncap; i++)
      if (cap[i] !== exp[i]) begin
        if (bad == 0) chk(1'b0, {req, " nibble content"}, cap[i], exp[i]);
        bad++;
      end
    if (bad == 0) chk(1'b1, req, 0, 0);
    @(negedge clk);
    chk(done === 1'b0, "R9 done single cycle", done, 0);
  endtask

  task automatic t_reset;
    chk(tx_en === 1'b0 && busy === 1'b0, "R1 reset outputs", {tx_en, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({tx_en, busy, done, fifo_rd} === 4'b0, "R1 after reset", {tx_en, busy, done, fifo_rd}, 0);
  endtask

  task automatic t_gate;
    bit seen = 0;
    load(20, 1); arm(20, 1, 1, 30); chan_free = 1'b1;
    repeat (40) begin @(negedge clk); seen |= tx_en; end
    chk(!seen, "R2 below threshold holds off", seen, 0);
    chan_free = 1'b0; threshold = 20;
    repeat (40) begin @(negedge clk); seen |= tx_en; end
    chk(!seen, "R2 channel busy holds off", seen, 0);
    chan_free = 1'b1;
    @(negedge clk);
    chk(tx_en === 1'b1, "R2 start one cycle after gate opens", tx_en, 1);
    finish_frame(20, 1, 1, "R5 padded frame with FCS");
  endtask

  task automatic t_frame(input int len, input bit pe, input bit fe, input int seed, input string req);
    chan_free = 1'b0;
    if (seed >= 0) load(len, seed);
    arm(len, pe, fe, (len < 16) ? len : 16);
    chan_free = 1'b1;
    finish_frame(len, pe, fe, req);
    repeat (IFG + 2) @(negedge clk);
    chk(busy === 1'b0, "R9 busy clears after gap", busy, 0);
  endtask

  task automatic t_known_crc;
    string s = "123456789";
    for (int i = 0; i < 9; i++) mem[i] = s[i];
    t_frame(9, 0, 1, -1, "R7 known check value");
    chk(cap[16 + 18] == 4'h6 && cap[16 + 25] == 4'hC, "R7 FCS nibble order",
        {cap[16 + 18], cap[16 + 25]}, 8'h6C);
  endtask

  task automatic t_gap;
    int low = 0;
    chan_free = 1'b0; load(30, 7); arm(30, 0, 1, 16); chan_free = 1'b1;
    finish_frame(30, 0, 1, "R6 unpadded short frame");
    load(25, 9); flen = 25; pad_en = 1; fcs_en = 1; threshold = 16;
    ncap = 0; nrd = 0; ptr_clr = 1'b1; low = 2;
    @(negedge clk); ptr_clr = 1'b0;
    while (!tx_en && low < 200) begin @(negedge clk); low++; end
    chk(low >= IFG && low <= IFG + 3, "R10 gap before back-to-back frame", low, IFG);
    finish_frame(25, 1, 1, "R10 second frame intact");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_gate();
    t_frame(20, 0, 1, 2, "R6 no pad when disabled");
    t_frame(70, 1, 1, 3, "R6 long frame not padded");
    t_frame(60, 1, 1, 4, "R5 exactly minimum length");
    t_frame(59, 1, 1, 5, "R5 one byte short");
    t_frame(20, 1, 0, 6, "R8 padded frame without FCS");
    t_frame(33, 0, 0, 8, "R8 raw frame without FCS");
    t_frame(64, 0, 1, 10, "R3 R4 long frame preamble and order");
    t_known_crc();
    t_gap();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule